// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Port with Collision and Mode-Fault Detection

This block exchanges one byte at a time over a four-wire synchronous serial link and can be either the clock master or a clocked slave, chosen by a control bit. Each serial clock cycle moves one bit out and one bit in at the same time, most significant bit first, on two separate data lines. The idle level of the serial clock and the edge on which data is sampled can both be set. As master the block makes the serial clock from the system clock, using one of four dividers. As slave it follows an external clock while its select input is held low. The select input and the slave's clock and data inputs pass through a two-flop synchronizer.

A host reaches the block through a small register port. It has a control register at address 0, a status register at address 1 and a data register at address 2. Reads are combinational. Read side effects and all writes take effect at the clock edge. Bytes travel over this register port rather than a stream, so there is no back-pressure. A data write that arrives while a byte is moving is dropped and flagged, and the host must wait for the transfer-complete flag before writing again. The block also watches for a second master. If the select input goes low while the block is the enabled master, it leaves master mode and releases every output driver.

Control register bits: bit0 interrupt enable, bit1 port enable, bit2 master select, bit3 clock idle level (CPOL), bit4 clock phase (CPHA), bits 6:5 rate, bit7 spare read/write storage. Status register bits: bit0 transfer complete, bit1 write collision, bit2 mode fault, bit3 busy.

Top module: `spi_port`

## Requirements
- R1: After reset the control and status registers read 0, the irq output is low, and sck_oe, mosi_oe and miso_oe are all low.
- R2: With control bits port enable and master select both set, a write to the data register starts an 8-bit full-duplex exchange. mosi_o carries the written byte MSB first, and the byte sampled from miso_i can then be read at the data address. Rate settings 0, 1, 2 and 3 give a serial clock period of 8, 16, 32 and 64 system clocks.
- R3: When idle, the serial clock sits at the CPOL level. With CPHA=0 the first bit is valid before the first clock edge, data is sampled on the leading edge and changed on the trailing edge. With CPHA=1 data is changed on the leading edge and sampled on the trailing edge.
- R4: With port enable set, master select clear and ss_n_i low, miso_oe is high and the block shifts using sck_i and mosi_i under the same CPOL/CPHA rules. With CPHA=0 the first bit of the written byte is on miso_o as soon as the synchronized select is seen low, before any clock edge.
- R5: Status bit0 (transfer complete) sets after the eighth bit. It clears when the host reads status with the flag set and then reads or writes the data register.
- R6: A data register write during a transfer sets status bit1 (write collision). The written byte is discarded and the running transfer completes with its original data. The flag clears in the same way as bit0.
- R7: If ss_n_i is low while the block is the enabled master, status bit2 (mode fault) sets, control bits enable and master select clear, and sck_oe and mosi_oe drop. Bit2 clears when the host reads status with it set and then writes the control register.
- R8: irq is high exactly when the interrupt-enable bit is set and transfer complete or mode fault is set.
- R9: Status bit3 reads 1 while a byte is being shifted and 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (for read side effects) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe | output | 1 | Master data driver enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | Slave data driver enable |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
The assertions check on every cycle that the master and slave data drivers are never both enabled, that a seen mode fault releases the master drivers on the next cycle, that a colliding data write always leaves the collision flag set, and that the complete flag rises only at the end of a busy period. Only the bench scenarios can show the actual bit order and sampling edges in all four clock modes, the measured clock period for each rate, the slave presenting its first bit before any edge, and a discarded write leaving the transfer intact. They also cover the two-step clearing of each status flag.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int DATA_W = 8;
  localparam int RATE_W = 2;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic              spare;
    logic [RATE_W-1:0] rate;
    logic              cpha;
    logic              cpol;
    logic              master;
    logic              en;
    logic              irq_en;
  } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int MIN_DIV = 8,
  parameter int RATE_W  = 2,
  parameter int BITS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              cpol,
  input  logic [RATE_W-1:0] rate,
  output logic              busy,
  output logic              sck,
  output logic              lead_ev,
  output logic              trail_ev
);
  localparam int BASE_HALF = MIN_DIV / 2;
  localparam int MAX_HALF  = BASE_HALF << ((1 << RATE_W) - 1);
  localparam int CW        = $clog2(MAX_HALF) + 1;
  localparam int EW        = $clog2(2 * BITS);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * BITS - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] half;
  logic [EW-1:0] edge_idx;
  logic          tick;

  assign half     = CW'(BASE_HALF) << rate;
  assign tick     = busy && (cnt == half - 1'b1);
  assign lead_ev  = tick && !edge_idx[0];
  assign trail_ev = tick &&  edge_idx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      edge_idx <= '0;
      sck      <= 1'b0;
    end else if (abort) begin
      busy <= 1'b0;
      sck  <= cpol;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= '0;
      edge_idx <= '0;
      sck      <= cpol;
    end else if (tick) begin
      cnt      <= '0;
      sck      <= ~sck;
      edge_idx <= edge_idx + 1'b1;
      if (edge_idx == LAST_EDGE) busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end else begin
      sck <= cpol;
    end
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         cpha,
  input  logic         lead_ev,
  input  logic         trail_ev,
  input  logic         sin,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         sout,
  output logic         in_xfer,
  output logic         done,
  output logic [W-1:0] rx
);
  localparam int CNTW = $clog2(W);

  logic [W-1:0]    shreg;
  logic [CNTW-1:0] bcnt;
  logic            mid;
  logic            sample_ev;
  logic            drive_ev;

  assign sample_ev = cpha ? trail_ev : lead_ev;
  assign drive_ev  = cpha ? lead_ev  : trail_ev;
  assign done      = trail_ev && (bcnt == CNTW'(W - 1));
  assign in_xfer   = mid || (bcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      sout  <= 1'b0;
      bcnt  <= '0;
      mid   <= 1'b0;
      rx    <= '0;
    end else if (load) begin
      shreg <= load_data;
      if (!cpha) sout <= load_data[W-1];
      bcnt  <= '0;
      mid   <= 1'b0;
    end else if (clear) begin
      bcnt <= '0;
      mid  <= 1'b0;
    end else begin
      if (sample_ev) shreg <= {shreg[W-2:0], sin};
      if (drive_ev)  sout  <= shreg[W-1];
      if (lead_ev)   mid   <= 1'b1;
      if (trail_ev) begin
        mid  <= 1'b0;
        bcnt <= done ? '0 : bcnt + 1'b1;
      end
      if (done) rx <= cpha ? {shreg[W-2:0], sin} : shreg;
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int MIN_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_n_i
);
  ctrl_t ctrl;
  logic  done_f, wcol_f, modf_f, stat_seen, modf_seen;
  logic  ss_s, sck_s, mosi_s, sck_q;
  logic  master_mode, slave_act, fault;
  logic  s_lead, s_trail, m_lead, m_trail, m_busy, m_sck;
  logic  lead_ev, trail_ev, sin, sout, in_xfer, xfer_done, busy_any;
  logic  wr_ctrl, wr_data, rd_stat, data_acc, load, start, clear;
  logic [DATA_W-1:0] rx_byte;

  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ss_n_i, sck_i, mosi_i}), .q({ss_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign master_mode = ctrl.en && ctrl.master;
  assign slave_act   = ctrl.en && !ctrl.master && !ss_s;
  assign fault       = master_mode && !ss_s;
  assign s_lead      = slave_act && (sck_q == ctrl.cpol) && (sck_s != ctrl.cpol);
  assign s_trail     = slave_act && (sck_q != ctrl.cpol) && (sck_s == ctrl.cpol);

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_data  = reg_wr && (reg_addr == ADDR_DATA);
  assign rd_stat  = reg_rd && (reg_addr == ADDR_STAT);
  assign data_acc = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
  assign busy_any = m_busy || in_xfer;
  assign load     = wr_data && !busy_any;
  assign start    = load && master_mode && !fault;
  assign clear    = fault || (!ctrl.master && !slave_act);

  spi_sclk_gen #(.MIN_DIV(MIN_DIV), .RATE_W(RATE_W), .BITS(DATA_W)) u_sclk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(fault),
    .cpol(ctrl.cpol), .rate(ctrl.rate), .busy(m_busy), .sck(m_sck),
    .lead_ev(m_lead), .trail_ev(m_trail)
  );

  assign lead_ev  = master_mode ? m_lead  : s_lead;
  assign trail_ev = master_mode ? m_trail : s_trail;
  assign sin      = ctrl.master ? miso_i : mosi_s;

  spi_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(clear), .cpha(ctrl.cpha),
    .lead_ev(lead_ev), .trail_ev(trail_ev), .sin(sin),
    .load(load), .load_data(reg_wdata), .sout(sout),
    .in_xfer(in_xfer), .done(xfer_done), .rx(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      done_f    <= 1'b0;
      wcol_f    <= 1'b0;
      modf_f    <= 1'b0;
      stat_seen <= 1'b0;
      modf_seen <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata);
      if (data_acc && stat_seen) begin
        done_f    <= 1'b0;
        wcol_f    <= 1'b0;
        stat_seen <= 1'b0;
      end
      if (rd_stat && (done_f || wcol_f)) stat_seen <= 1'b1;
      if (xfer_done) done_f <= 1'b1;
      if (wr_data && busy_any) wcol_f <= 1'b1;
      if (wr_ctrl && modf_seen) begin
        modf_f    <= 1'b0;
        modf_seen <= 1'b0;
      end
      if (rd_stat && modf_f) modf_seen <= 1'b1;
      if (fault) begin
        modf_f      <= 1'b1;
        ctrl.en     <= 1'b0;
        ctrl.master <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl;
      ADDR_STAT: reg_rdata = {4'b0, busy_any, modf_f, wcol_f, done_f};
      ADDR_DATA: reg_rdata = rx_byte;
      default:   reg_rdata = '0;
    endcase
  end

  assign sck_o   = m_sck;
  assign sck_oe  = master_mode;
  assign mosi_o  = sout;
  assign mosi_oe = master_mode;
  assign miso_o  = sout;
  assign miso_oe = slave_act;
  assign irq     = ctrl.irq_en && (done_f || modf_f);
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ctrl_en,
  input logic ctrl_master,
  input logic ss_s,
  input logic sck_oe,
  input logic mosi_oe,
  input logic miso_oe,
  input logic wr_data,
  input logic busy_any,
  input logic wcol_f,
  input logic done_f
);
  // R7
  modf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && ctrl_master && !ss_s) |=> (!sck_oe && !mosi_oe));

  // R4
  single_data_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mosi_oe && miso_oe));

  // R6
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy_any) |=> wcol_f);

  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> $past(busy_any));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl.en), .ctrl_master(ctrl.master),
  .ss_s(ss_s), .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe),
  .wr_data(wr_data), .busy_any(busy_any), .wcol_f(wcol_f), .done_f(done_f)
);

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
module spi_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

  int n_chk = 0, n_fail = 0, cyc = 0;

  spi_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // bench-side slave used when the DUT is master
  logic       mdl_on = 1'b0, mdl_cpol = 1'b0, mdl_cpha = 1'b0, mdl_prev = 1'b0;
  logic [7:0] mdl_tx = 8'h00, mdl_rx = 8'h00;
  int         mdl_last = 0, mdl_period = 0;

  always @(negedge clk) begin
    if (mdl_on && sck_o != mdl_prev) begin
      if (mdl_prev == mdl_cpol) begin
        if (mdl_last > 0) mdl_period = cyc - mdl_last;
        mdl_last = cyc;
      end
      if ((mdl_prev == mdl_cpol) ^ mdl_cpha) mdl_rx = {mdl_rx[6:0], mosi_o};
      else if (mdl_cpha) begin
        miso_i = mdl_tx[7];
        mdl_tx = mdl_tx << 1;
      end else begin
        mdl_tx = mdl_tx << 1;
        miso_i = mdl_tx[7];
      end
    end
    mdl_prev = sck_o;
  end

  function automatic logic [7:0] mk_ctrl(input logic ie, input logic en, input logic ms,
                                         input logic cpol, input logic cpha, input logic [1:0] rate);
    return {1'b0, rate, cpha, cpol, ms, en, ie};
  endfunction

  function automatic int exp_period(input logic [1:0] rate);
    return 8 << rate;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] slv, input logic cpol,
                             input logic cpha, input logic [1:0] rate, input logic ie);
    logic [7:0] st, rd;
    reg_write(2'd0, mk_ctrl(ie, 1'b1, 1'b1, cpol, cpha, rate));
    repeat (2) @(negedge clk);
    mdl_cpol = cpol; mdl_cpha = cpha; mdl_tx = slv; mdl_rx = 8'h00;
    mdl_last = 0; mdl_period = 0; miso_i = slv[7]; mdl_on = 1'b1;
    reg_write(2'd2, tx);
    repeat (16 * (4 << rate) + 8) @(negedge clk);
    mdl_on = 1'b0;
    chk(mdl_rx == tx, "R2 mosi byte", mdl_rx, tx);
    chk(mdl_period == exp_period(rate), "R2 sck period", mdl_period, exp_period(rate));
    chk(sck_o == cpol, "R3 idle level", sck_o, cpol);
    chk(irq == ie, "R8 irq on done", irq, ie);
    reg_read(2'd1, st);
    chk(st == 8'h01, "R5 done set, R9 idle", st, 8'h01);
    reg_read(2'd2, rd);
    chk(rd == slv, "R2 R3 rx byte", rd, slv);
    reg_read(2'd1, st);
    chk(st == 8'h00, "R5 done cleared", st, 8'h00);
  endtask

  task automatic slave_xfer(input logic [7:0] stx, input logic [7:0] mtx,
                            input logic cpol, input logic cpha);
    logic [7:0] brx, st, rd;
    sck_i = cpol;
    reg_write(2'd0, mk_ctrl(1'b0, 1'b1, 1'b0, cpol, cpha, 2'd0));
    reg_write(2'd2, stx);
    @(negedge clk); ss_n_i = 1'b0;
    repeat (12) @(negedge clk);
    chk(miso_oe == 1'b1, "R4 miso_oe", miso_oe, 1);
    if (!cpha) chk(miso_o == stx[7], "R4 first bit early", miso_o, stx[7]);
    brx = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        mosi_i = mtx[7-i];
        repeat (12) @(negedge clk);
        brx = {brx[6:0], miso_o};
        sck_i = ~cpol;
        repeat (12) @(negedge clk);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol;
        mosi_i = mtx[7-i];
        repeat (12) @(negedge clk);
        brx = {brx[6:0], miso_o};
        sck_i = cpol;
        repeat (12) @(negedge clk);
      end
    end
    repeat (12) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(brx == stx, "R4 miso byte", brx, stx);
    reg_read(2'd1, st);
    chk(st == 8'h01, "R5 slave done", st, 8'h01);
    reg_read(2'd2, rd);
    chk(rd == mtx, "R4 slave rx", rd, mtx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd, st, a_tx, a_sl;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_read(2'd0, rd);
    chk(rd == 8'h00, "R1 ctrl reset", rd, 0);
    reg_read(2'd1, st);
    chk(st == 8'h00, "R1 status reset", st, 0);
    chk({sck_oe, mosi_oe, miso_oe, irq} == 4'b0, "R1 outputs reset",
        {sck_oe, mosi_oe, miso_oe, irq}, 0);

    // directed: all four clock modes, every rate, corner bytes
    for (int m = 0; m < 4; m++)
      master_xfer(8'h81 ^ 8'(m), 8'h7E, m[1], m[0], 2'(m), 1'b1);
    master_xfer(8'h00, 8'hFF, 1'b0, 1'b0, 2'd0, 1'b0);
    master_xfer(8'hFF, 8'h00, 1'b1, 1'b1, 2'd0, 1'b0);

    // constrained random master transfers
    for (int k = 0; k < 6; k++)
      master_xfer(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                  2'($urandom_range(0, 2)), 1'($urandom));

    // R6 write collision during a slow transfer
    a_tx = 8'hC3; a_sl = 8'h5A;
    reg_write(2'd0, mk_ctrl(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3));
    repeat (2) @(negedge clk);
    mdl_cpol = 1'b0; mdl_cpha = 1'b0; mdl_tx = a_sl; mdl_rx = 8'h00;
    mdl_last = 0; miso_i = a_sl[7]; mdl_on = 1'b1;
    reg_write(2'd2, a_tx);
    repeat (100) @(negedge clk);
    reg_write(2'd2, 8'h3C);
    reg_read(2'd1, st);
    chk(st == 8'h0A, "R6 wcol set, R9 busy", st, 8'h0A);
    repeat (16 * 32 + 8) @(negedge clk);
    mdl_on = 1'b0;
    chk(mdl_rx == a_tx, "R6 transfer unchanged", mdl_rx, a_tx);
    reg_read(2'd1, st);
    chk(st == 8'h03, "R6 done and wcol", st, 8'h03);
    reg_read(2'd2, rd);
    chk(rd == a_sl, "R6 rx unchanged", rd, a_sl);
    reg_read(2'd1, st);
    chk(st == 8'h00, "R6 wcol cleared", st, 0);

    // R7 mode fault mid-transfer
    reg_write(2'd0, mk_ctrl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0));
    reg_write(2'd2, 8'h99);
    repeat (10) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (5) @(negedge clk);
    chk({sck_oe, mosi_oe, miso_oe} == 3'b0, "R7 drivers off",
        {sck_oe, mosi_oe, miso_oe}, 0);
    chk(irq == 1'b1, "R8 irq on fault", irq, 1);
    ss_n_i = 1'b1;
    reg_read(2'd0, rd);
    chk(rd == mk_ctrl(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0), "R7 ctrl bits cleared",
        rd, mk_ctrl(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0));
    reg_read(2'd1, st);
    chk(st == 8'h04, "R7 modf set", st, 8'h04);
    repeat (4) @(negedge clk);
    reg_write(2'd0, 8'h00);
    reg_read(2'd1, st);
    chk(st == 8'h00, "R7 modf cleared", st, 0);
    chk(irq == 1'b0, "R8 irq low", irq, 0);

    // slave mode: directed modes then random bytes
    for (int m = 0; m < 4; m++)
      slave_xfer(8'hA5 ^ 8'(m), 8'h1E, m[1], m[0]);
    for (int k = 0; k < 4; k++)
      slave_xfer(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule